// File: doc/BRIEF.md
# Color Lookup Host Register Port

This block is the host side of a color lookup device. A host reaches a small register file over an 8-bit bus. It uses a 3-bit register select and separate read and write strobes. Each strobe is high for one clock to mark one access. Behind the port sit two color stores: a 256-entry palette and a 16-entry overlay table. Each entry holds a 24-bit red/green/blue word. The port turns sequences of byte accesses into whole-word write requests and read requests toward those stores.

Color bytes always move in red, green, blue order. A hidden counter that runs modulo three tracks the position inside the triplet. The visible 8-bit address advances after every completed triplet. Loading the address in read mode fetches the first word at once, so the host can start reading bytes immediately. The port also holds an 8-bit command register whose bits drive control outputs; bit 1 selects 6-bit color bytes. It also holds a pixel read mask that is copied onto all three channels.

The storage read path is combinational: `rd_word` must be valid in the same cycle that `rd_req` is high. A write request is taken by the storage at the clock edge that ends the cycle in which `wr_req` is high.

Top module: `clut_host_port`

## Requirements
- R1: A write with `sel[1:0]` equal to 00 or 11 loads `wdata` into the address and clears the hidden triplet counter. A select of 011 (palette) or 111 (overlay) also raises `rd_req` in that cycle for location `wdata`, copies `rd_word` into the red, green and blue holding bytes, and leaves the address at `wdata`+1.
- R2: Three writes to select 001 supply red, green and blue in that order. On the blue write, `wr_req` is high with `wr_ovl`=0, `wr_addr` set to the current address, and `wr_word` = {red, green, blue} with red in bits 23:16. The address then increments by one.
- R3: After the blue byte of a palette access at address FFh, the address wraps to 00h.
- R4: Each read of select 001 or 101 returns the holding byte chosen by the triplet counter (red, then green, then blue). The blue read raises `rd_req` at the current address, reloads all three holding bytes and increments the address.
- R5: A read of any select with `sel[1:0]` equal to 00 or 11 returns the 8-bit address. It changes neither the address nor the triplet counter, so a triplet in progress resumes where it stopped.
- R6: Select 101 accesses the overlay table in the same way as the palette. Storage addresses for the overlay keep only address bits 3:0, with bits 7:4 forced to zero. A blue write aimed at overlay location 0 raises no `wr_req`, but the address still increments.
- R7: When command bit 1 is set, color writes store `{wdata[5:0],2'b00}` and color reads return `{2'b00, byte[7:2]}`. When it is clear, bytes pass unchanged.
- R8: Select 110 writes and reads the command register. Its value appears on `ctrl` from the cycle after the write.
- R9: Select 010 writes and reads the pixel read mask. The stored byte appears on all three bytes of `pixel_mask`. The mask resets to FFh.
- R10: A cycle with both strobes high performs no access: no request, no state change. `rdata` is zero whenever no read is in progress.
- R11: After reset the address reads 00h and the triplet counter starts at red.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register select |
| rd_stb | input | 1 | One-cycle read access strobe |
| wr_stb | input | 1 | One-cycle write access strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, valid while `rd_stb` is high |
| wr_req | output | 1 | Store one word into palette or overlay |
| wr_ovl | output | 1 | Write targets the overlay table |
| wr_addr | output | 8 | Storage write address |
| wr_word | output | 24 | Storage write word {red, green, blue} |
| rd_req | output | 1 | Fetch one word from palette or overlay |
| rd_ovl | output | 1 | Fetch targets the overlay table |
| rd_addr | output | 8 | Storage read address |
| rd_word | input | 24 | Fetched word, valid in the `rd_req` cycle |
| ctrl | output | 8 | Command register contents |
| pixel_mask | output | 24 | Read mask replicated per channel |

## Verification
The properties assume that each strobe pulse is exactly one access and that the storage returns `rd_word` combinationally in the request cycle. They also assume that the command register has been written before any 6-bit formatting is relied on, since it has no reset value. The stimulus meets these conditions in several ways. It raises a strobe for a single clock, with an idle cycle between accesses. It models both stores as arrays read without delay. It writes the command register before any color traffic. The one cycle with both strobes high is deliberate, and is there to exercise R10.

// File: rtl/clut_host_port.sv
module clut_host_port #(
  parameter int AW = 8,
  parameter int OW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    sel,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          wr_req,
  output logic          wr_ovl,
  output logic [AW-1:0] wr_addr,
  output logic [23:0]   wr_word,
  output logic          rd_req,
  output logic          rd_ovl,
  output logic [AW-1:0] rd_addr,
  input  logic [23:0]   rd_word,
  output logic [7:0]    ctrl,
  output logic [23:0]   pixel_mask
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] addr;
  logic [1:0]    sub;
  logic [7:0]    hold_r, hold_g, hold_b, mask, cmd;

  wire acc_wr   = wr_stb & ~rd_stb;
  wire acc_rd   = rd_stb & ~wr_stb;
  wire sel_addr = ~(sel[0] ^ sel[1]);
  wire sel_data = (sel[1:0] == 2'b01);
  wire sel_misc = (sel[1:0] == 2'b10);
  wire ovl      = sel[2];
  wire six      = cmd[1];
  wire last     = (sub == 2'd2);

  wire [7:0] wbyte    = six ? {wdata[5:0], 2'b00} : wdata;
  wire [AW-1:0] waddr = {{(AW-8){1'b0}}, wdata};
  wire [AW-1:0] st_addr = ovl ? {{(AW-OW){1'b0}}, addr[OW-1:0]} : addr;
  wire [AW-1:0] ld_addr = ovl ? {{(AW-OW){1'b0}}, waddr[OW-1:0]} : waddr;

  wire prefetch = acc_wr & sel_addr & sel[0];
  wire blue_rd  = acc_rd & sel_data & last;
  wire blue_wr  = acc_wr & sel_data & last;
  wire reserved = ovl & (addr[OW-1:0] == '0);

  assign wr_req     = blue_wr & ~reserved;
  assign wr_ovl     = ovl;
  assign wr_addr    = st_addr;
  assign wr_word    = {hold_r, hold_g, wbyte};
  assign rd_req     = prefetch | blue_rd;
  assign rd_ovl     = ovl;
  assign rd_addr    = sel_addr ? ld_addr : st_addr;
  assign ctrl       = cmd;
  assign pixel_mask = {3{mask}};

  logic [7:0] cur;
  always_comb begin
    case (sub)
      2'd0:    cur = hold_r;
      2'd1:    cur = hold_g;
      default: cur = hold_b;
    endcase
  end

  always_comb begin
    rdata = 8'h00;
    if (acc_rd) begin
      if (sel_addr)      rdata = addr[7:0];
      else if (sel_data) rdata = six ? {2'b00, cur[7:2]} : cur;
      else               rdata = ovl ? cmd : mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr   <= '0;
      sub    <= 2'd0;
      mask   <= 8'hFF;
      hold_r <= 8'h00;
      hold_g <= 8'h00;
      hold_b <= 8'h00;
    end else if (acc_wr) begin
      if (sel_addr) begin
        sub <= 2'd0;
        if (sel[0]) begin
          addr <= waddr + ONE;
          {hold_r, hold_g, hold_b} <= rd_word;
        end else begin
          addr <= waddr;
        end
      end else if (sel_data) begin
        case (sub)
          2'd0:    hold_r <= wbyte;
          2'd1:    hold_g <= wbyte;
          default: hold_b <= wbyte;
        endcase
        sub <= last ? 2'd0 : sub + 2'd1;
        if (last) addr <= addr + ONE;
      end else if (sel_misc && !ovl) begin
        mask <= wdata;
      end
    end else if (acc_rd && sel_data) begin
      sub <= last ? 2'd0 : sub + 2'd1;
      if (last) begin
        addr <= addr + ONE;
        {hold_r, hold_g, hold_b} <= rd_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (acc_wr && sel_misc && ovl) cmd <= wdata;
  end
endmodule

module clut_host_port_chk #(
  parameter int AW = 8,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    sel,
  input logic          rd_stb,
  input logic          wr_stb,
  input logic [7:0]    rdata,
  input logic          wr_req,
  input logic          wr_ovl,
  input logic [AW-1:0] wr_addr,
  input logic          rd_req,
  input logic [7:0]    ctrl,
  input logic [AW-1:0] addr,
  input logic [1:0]    sub
);
  wire addr_sel = ~(sel[0] ^ sel[1]);
  wire data_sel = (sel[1:0] == 2'b01);

  p_sub_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub != 2'd3);

  p_req_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  p_palette_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ovl) |=> (addr == $past(addr) + 1'b1) && (sub == 2'd0));

  p_ovl_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_ovl) |-> (wr_addr[AW-1:OW] == '0) && (wr_addr[OW-1:0] != '0));

  p_addr_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !rd_stb && addr_sel) |=> (sub == 2'd0));

  p_addr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && addr_sel) |=> $stable(addr) && $stable(sub));

  p_six_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !wr_stb && data_sel && ctrl[1]) |-> (rdata[7:6] == 2'b00));

  p_both_noop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb) |-> !wr_req && !rd_req && (rdata == 8'h00) ##1 $stable(addr) && $stable(sub));

  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |-> (rdata == 8'h00));
endmodule

bind clut_host_port clut_host_port_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
  .rdata(rdata), .wr_req(wr_req), .wr_ovl(wr_ovl), .wr_addr(wr_addr),
  .rd_req(rd_req), .ctrl(ctrl), .addr(addr), .sub(sub)
);

// File: tb/clut_host_port_bench.sv
module clut_host_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wr_req, wr_ovl, rd_req, rd_ovl;
  logic [7:0] wr_addr, rd_addr, ctrl;
  logic [23:0] wr_word, rd_word, pixel_mask;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit bad_ovl0 = 1'b0;

  logic [23:0] pal [256];
  logic [23:0] ovt [16];

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2 clk = ~clk;

  clut_host_port u_clut_host_port (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata), .wr_req(wr_req), .wr_ovl(wr_ovl),
    .wr_addr(wr_addr), .wr_word(wr_word), .rd_req(rd_req), .rd_ovl(rd_ovl),
    .rd_addr(rd_addr), .rd_word(rd_word), .ctrl(ctrl), .pixel_mask(pixel_mask)
  );

  always_comb rd_word = rd_ovl ? ovt[rd_addr[3:0]] : pal[rd_addr];

  always @(posedge clk) begin
    if (wr_req) begin
      if (wr_ovl) begin
        ovt[wr_addr[3:0]] <= wr_word;
        if (wr_addr[3:0] == 4'd0) bad_ovl0 <= 1'b1;
      end else begin
        pal[wr_addr] <= wr_word;
      end
    end
  end

  always @(negedge clk) begin
    if (rd_stb && !wr_stb) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic acc(input bit w, input bit r, input logic [2:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    sel = s; wdata = d; wr_stb = w; rd_stb = r;
    @(posedge clk); #1;
    wr_stb = 1'b0; rd_stb = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    acc(1'b1, 1'b0, s, d);
  endtask

  task automatic rd(input logic [2:0] s, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    acc(1'b0, 1'b1, s, 8'h00);
  endtask

  task automatic chk(input string t, input logic [23:0] a, input logic [23:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, a, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pal[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A};
    for (int i = 0; i < 16; i++)  ovt[i] = {4'hE, i[3:0], 8'h80 | i[7:0], 8'h0C};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(3'b000, 8'h00, "R11 reset address");
    chk("R9 reset mask", pixel_mask, 24'hFFFFFF);
    wr(3'b110, 8'h00);
    chk("R8 command write", {16'h0, ctrl}, 24'h000000);

    wr(3'b000, 8'h10);
    wr(3'b001, 8'hA1);
    rd(3'b011, 8'h10, "R5 address read mid-triplet");
    wr(3'b001, 8'hB2);
    wr(3'b001, 8'hC3);
    rd(3'b100, 8'h11, "R2 address after blue");
    wr(3'b011, 8'h10);
    rd(3'b000, 8'h11, "R1 prefetch increments");
    rd(3'b001, 8'hA1, "R2 red");
    rd(3'b001, 8'hB2, "R2 green");
    rd(3'b001, 8'hC3, "R2 blue");

    wr(3'b011, 8'h05);
    rd(3'b000, 8'h06, "R1 read-mode load");
    rd(3'b001, 8'h05, "R4 red 5");
    rd(3'b001, 8'hFA, "R4 green 5");
    rd(3'b001, 8'h5F, "R4 blue 5");
    rd(3'b001, 8'h06, "R4 red 6");
    rd(3'b001, 8'hF9, "R4 green 6");
    rd(3'b001, 8'h5C, "R4 blue 6");
    rd(3'b000, 8'h08, "R4 address after two triplets");

    wr(3'b000, 8'hFE);
    wr(3'b001, 8'h11); wr(3'b001, 8'h12); wr(3'b001, 8'h13);
    wr(3'b001, 8'h21); wr(3'b001, 8'h22); wr(3'b001, 8'h23);
    wr(3'b001, 8'h31); wr(3'b001, 8'h32); wr(3'b001, 8'h33);
    rd(3'b000, 8'h01, "R3 wrap after FF");
    wr(3'b011, 8'hFF);
    rd(3'b001, 8'h21, "R3 red FF");
    rd(3'b001, 8'h22, "R3 green FF");
    rd(3'b001, 8'h23, "R3 blue FF");
    rd(3'b001, 8'h31, "R3 red 00");
    rd(3'b001, 8'h32, "R3 green 00");
    rd(3'b001, 8'h33, "R3 blue 00");
    rd(3'b000, 8'h02, "R3 address after read wrap");

    wr(3'b100, 8'h13);
    wr(3'b101, 8'h44); wr(3'b101, 8'h55); wr(3'b101, 8'h66);
    rd(3'b100, 8'h14, "R6 overlay address step");
    wr(3'b111, 8'hF3);
    rd(3'b111, 8'hF4, "R6 overlay load keeps full address");
    rd(3'b101, 8'h44, "R6 overlay red");
    rd(3'b101, 8'h55, "R6 overlay green");
    rd(3'b101, 8'h66, "R6 overlay blue");
    wr(3'b100, 8'h00);
    wr(3'b101, 8'h01); wr(3'b101, 8'h02); wr(3'b101, 8'h03);
    chk("R6 reserved overlay write suppressed", {23'h0, bad_ovl0}, 24'h0);
    rd(3'b100, 8'h01, "R6 reserved still increments");

    wr(3'b110, 8'h02);
    chk("R8 ctrl output", {16'h0, ctrl}, 24'h000002);
    rd(3'b110, 8'h02, "R8 command read");
    wr(3'b000, 8'h40);
    wr(3'b001, 8'hFF); wr(3'b001, 8'hC1); wr(3'b001, 8'h3F);
    wr(3'b011, 8'h40);
    rd(3'b001, 8'h3F, "R7 six-bit red");
    rd(3'b001, 8'h01, "R7 six-bit green");
    rd(3'b001, 8'h3F, "R7 six-bit blue");
    wr(3'b110, 8'h00);
    wr(3'b011, 8'h40);
    rd(3'b001, 8'hFC, "R7 stored red");
    rd(3'b001, 8'h04, "R7 stored green");
    rd(3'b001, 8'hFC, "R7 stored blue");

    wr(3'b010, 8'h0F);
    chk("R9 mask replicated", pixel_mask, 24'h0F0F0F);
    rd(3'b010, 8'h0F, "R9 mask read");

    acc(1'b1, 1'b1, 3'b000, 8'h77);
    rd(3'b000, 8'h42, "R10 both strobes ignored");

    repeat (4) @(posedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 24'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule